// File: doc/BRIEF.md
# Tag Check Fault Reporter

This block receives one tag-mismatch event per cycle and decides how the fault is reported. A 2-bit check-mode field is taken from a 64-bit control word supplied for the translation regime. Which bits hold the field depends on whether the access was unprivileged. The field selects one of three actions: a synchronous abort request, a sticky bit in an asynchronous status bank, or a reserved-configuration flag that causes nothing else to happen.

The abort request is registered as a single-cycle pulse. The faulting address and a syndrome byte are registered with it. The syndrome holds a fixed fault status code, the write flag and the unprivileged flag.

The asynchronous bank keeps two sticky bits for each of four exception levels. A fault sets one bit in the bank of the level it is reported against. A bit is cleared only by an explicit clear aimed at its level.

Top module: `tag_fault_reporter`

## Requirements
- R1: While reset is asserted, and after it is released, `abort_req` and `rsvd_cfg` are 0, and every bit of `async_status` is 0.
- R2: The mode field is `ctrl_word[39:38]` when `evt_unpriv` is 1. Otherwise it is `ctrl_word[41:40]`. The field that is not selected has no effect.
- R3: An event with mode 1 produces `abort_req` high for one cycle, in the cycle after the event. For each further mode-1 event there is one more pulse.
- R4: An event with mode 1 loads `abort_addr` with the event address. It loads `abort_syndrome` with bits [5:0] = 0x11, bit 6 = write flag and bit 7 = unprivileged flag. The pulse and these two values appear in the same cycle.
- R5: An event with mode 2 produces no abort. In the next cycle it sets one bit of `async_status`. The bit index is 2*L + S. L is 0 for an unprivileged access and `evt_regime_el` for any other access.
- R6: The select bit S is `evt_addr[55]` when `evt_two_ranges` is 1, and 0 when it is 0.
- R7: A set status bit stays set across later events until it is cleared. New events OR further bits into the bank.
- R8: An event with mode 3 produces no abort and does not change `async_status`. It pulses `rsvd_cfg` for one cycle, in the cycle after the event.
- R9: When `clr_en` is 1, both bits of level `clr_el` are cleared in the next cycle. If the same cycle also sets a bit in that level, the set bit ends up 1.
- R10: When `evt_valid` is 0 there is no abort, no `rsvd_cfg` pulse and no status change, whatever the control word holds. A valid event with mode 0 breaks the input contract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Tag-mismatch event present this cycle |
| evt_addr | input | 64 | Faulting address |
| evt_write | input | 1 | Access was a write |
| evt_unpriv | input | 1 | Access was unprivileged (level 0) |
| evt_regime_el | input | 2 | Exception level that owns the regime |
| evt_two_ranges | input | 1 | Regime splits the address space into two ranges |
| ctrl_word | input | 64 | System control value for the regime |
| clr_en | input | 1 | Clear the status bits of one level |
| clr_el | input | 2 | Level to clear |
| abort_req | output | 1 | Single-cycle synchronous abort request |
| abort_addr | output | 64 | Address of the latest abort |
| abort_syndrome | output | 8 | Syndrome of the latest abort |
| async_status | output | 8 | Sticky status bits, two per level, level L in bits [2L+1:2L] |
| rsvd_cfg | output | 1 | Single-cycle pulse for an event in reserved mode 3 |

## Verification
The vectors place different values in the two candidate mode fields. A wrong field choice therefore shows up as the wrong action, or as an abort where none should occur. Asynchronous events sweep levels 0 to 3 and both privilege kinds, with bit 55 set and clear and the two-range flag on and off. This separates an error in the level mapping from an error in the select bit, and an event repeated on a bit already set shows whether the bits are sticky. Directed cases cover back-to-back aborts with different addresses, a clear in the same cycle as a set on the same level, and idle cycles with active mode fields in the control word.

// File: rtl/tfr_pkg.sv
package tfr_pkg;

  typedef enum logic [1:0] {
    CHK_NONE  = 2'd0,
    CHK_SYNC  = 2'd1,
    CHK_ASYNC = 2'd2,
    CHK_RSVD  = 2'd3
  } chk_mode_e;

  localparam int unsigned SEL_PER_LEVEL = 2;
  localparam logic [5:0]  TAG_FSC       = 6'h11;

  typedef struct packed {
    logic       lower;
    logic       wnr;
    logic [5:0] fsc;
  } syndrome_t;

  function automatic syndrome_t make_syndrome(input logic wr, input logic unpriv);
    syndrome_t s;
    s.lower = unpriv;
    s.wnr   = wr;
    s.fsc   = TAG_FSC;
    return s;
  endfunction

endpackage

// File: rtl/tfr_rst_sync.sv
module tfr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tfr_mode_sel.sv
module tfr_mode_sel
  import tfr_pkg::*;
#(
  parameter int unsigned CTRL_W     = 64,
  parameter int unsigned UNPRIV_LSB = 38,
  parameter int unsigned PRIV_LSB   = 40
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              unpriv,
  output chk_mode_e         mode
);
  logic [1:0] field_user;
  logic [1:0] field_priv;
  logic       unused_ctrl_bits;

  assign field_user = ctrl_word[UNPRIV_LSB +: 2];
  assign field_priv = ctrl_word[PRIV_LSB +: 2];
  assign unused_ctrl_bits = ^ctrl_word;

  always_comb begin
    if (unpriv) mode = chk_mode_e'(field_user);
    else        mode = chk_mode_e'(field_priv);
  end
endmodule

// File: rtl/tfr_abort_gen.sv
module tfr_abort_gen
  import tfr_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              unpriv,
  output logic              req,
  output logic [ADDR_W-1:0] req_addr,
  output syndrome_t         req_syn
);
  logic              req_d;
  logic [ADDR_W-1:0] addr_d;
  syndrome_t         syn_d;
  logic              load_en;

  always_comb begin
    load_en = fire;
    req_d   = fire;
    addr_d  = req_addr;
    syn_d   = req_syn;
    if (load_en) begin
      addr_d = addr;
      syn_d  = make_syndrome(wr, unpriv);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req      <= 1'b0;
      req_addr <= '0;
      req_syn  <= '0;
    end else begin
      req <= req_d;
      if (load_en) begin
        req_addr <= addr_d;
        req_syn  <= syn_d;
      end
    end
  end
endmodule

// File: rtl/tfr_status_bank.sv
module tfr_status_bank
  import tfr_pkg::*;
#(
  parameter int unsigned NUM_EL = 4,
  localparam int unsigned EL_W  = $clog2(NUM_EL),
  localparam int unsigned SEL_W = $clog2(SEL_PER_LEVEL)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             set_en,
  input  logic [EL_W-1:0]                  set_el,
  input  logic [SEL_W-1:0]                 set_sel,
  input  logic                             clr_en,
  input  logic [EL_W-1:0]                  clr_el,
  output logic [NUM_EL*SEL_PER_LEVEL-1:0]  status
);
  for (genvar g = 0; g < NUM_EL; g++) begin : g_level
    logic [SEL_PER_LEVEL-1:0] bits_q;
    logic [SEL_PER_LEVEL-1:0] bits_d;
    logic                     hit_set;
    logic                     hit_clr;

    assign hit_set = set_en && (set_el == EL_W'(g));
    assign hit_clr = clr_en && (clr_el == EL_W'(g));

    always_comb begin
      bits_d = bits_q;
      if (hit_clr) bits_d = '0;
      if (hit_set) bits_d[set_sel] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                bits_q <= '0;
      else if (hit_set || hit_clr) bits_q <= bits_d;
    end

    assign status[g*SEL_PER_LEVEL +: SEL_PER_LEVEL] = bits_q;
  end
endmodule

// File: rtl/tag_fault_reporter.sv
module tag_fault_reporter
  import tfr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned CTRL_W     = 64,
  parameter int unsigned NUM_EL     = 4,
  parameter int unsigned UNPRIV_LSB = 38,
  parameter int unsigned PRIV_LSB   = 40,
  parameter int unsigned SEL_BIT    = 55,
  localparam int unsigned EL_W      = $clog2(NUM_EL),
  localparam int unsigned SEL_W     = $clog2(SEL_PER_LEVEL),
  localparam int unsigned STAT_W    = NUM_EL * SEL_PER_LEVEL,
  localparam int unsigned SYN_W     = $bits(syndrome_t)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_write,
  input  logic              evt_unpriv,
  input  logic [EL_W-1:0]   evt_regime_el,
  input  logic              evt_two_ranges,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              clr_en,
  input  logic [EL_W-1:0]   clr_el,
  output logic              abort_req,
  output logic [ADDR_W-1:0] abort_addr,
  output logic [SYN_W-1:0]  abort_syndrome,
  output logic [STAT_W-1:0] async_status,
  output logic              rsvd_cfg
);
  logic        rst_n_int;
  chk_mode_e   mode;
  logic        fire_sync;
  logic        fire_async;
  logic        fire_rsvd;
  logic [EL_W-1:0]  tgt_el;
  logic [SEL_W-1:0] tgt_sel;
  syndrome_t   syn_q;
  logic        rsvd_d;
  logic        rsvd_q;

  tfr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tfr_mode_sel #(
    .CTRL_W     (CTRL_W),
    .UNPRIV_LSB (UNPRIV_LSB),
    .PRIV_LSB   (PRIV_LSB)
  ) u_mode (
    .ctrl_word (ctrl_word),
    .unpriv    (evt_unpriv),
    .mode      (mode)
  );

  always_comb begin
    fire_sync  = evt_valid && (mode == CHK_SYNC);
    fire_async = evt_valid && (mode == CHK_ASYNC);
    fire_rsvd  = evt_valid && (mode == CHK_RSVD);
    tgt_el     = evt_unpriv ? '0 : evt_regime_el;
    tgt_sel    = evt_two_ranges ? SEL_W'(evt_addr[SEL_BIT]) : '0;
  end

  tfr_abort_gen #(.ADDR_W(ADDR_W)) u_abort (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .fire     (fire_sync),
    .addr     (evt_addr),
    .wr       (evt_write),
    .unpriv   (evt_unpriv),
    .req      (abort_req),
    .req_addr (abort_addr),
    .req_syn  (syn_q)
  );

  assign abort_syndrome = syn_q;

  tfr_status_bank #(.NUM_EL(NUM_EL)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .set_en  (fire_async),
    .set_el  (tgt_el),
    .set_sel (tgt_sel),
    .clr_en  (clr_en),
    .clr_el  (clr_el),
    .status  (async_status)
  );

  always_comb begin
    rsvd_d = fire_rsvd;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) rsvd_q <= 1'b0;
    else            rsvd_q <= rsvd_d;
  end

  assign rsvd_cfg = rsvd_q;
endmodule

// File: rtl/tfr_chk.sv
module tfr_chk #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned CTRL_W     = 64,
  parameter int unsigned EL_W       = 2,
  parameter int unsigned STAT_W     = 8,
  parameter int unsigned UNPRIV_LSB = 38,
  parameter int unsigned PRIV_LSB   = 40
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic              evt_unpriv,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              clr_en,
  input logic              abort_req,
  input logic [STAT_W-1:0] async_status,
  input logic              rsvd_cfg
);
  logic [1:0] fld;
  assign fld = evt_unpriv ? ctrl_word[UNPRIV_LSB +: 2] : ctrl_word[PRIV_LSB +: 2];

  // R3
  sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && fld == 2'd1) |=> abort_req);

  // R3
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> ($past(evt_valid) && $past(fld) == 2'd1));

  // R5
  async_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && fld == 2'd2) |=> !abort_req);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((async_status & $past(async_status)) == $past(async_status)));

  // R8
  rsvd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && fld == 2'd3 && !clr_en) |=> (rsvd_cfg && !abort_req && $stable(async_status)));

  // R10
  no_off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (fld != 2'd0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !clr_en) |=> (!abort_req && !rsvd_cfg && $stable(async_status)));
endmodule

bind tag_fault_reporter tfr_chk #(
  .ADDR_W     (ADDR_W),
  .CTRL_W     (CTRL_W),
  .EL_W       (EL_W),
  .STAT_W     (STAT_W),
  .UNPRIV_LSB (UNPRIV_LSB),
  .PRIV_LSB   (PRIV_LSB)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_valid    (evt_valid),
  .evt_unpriv   (evt_unpriv),
  .ctrl_word    (ctrl_word),
  .clr_en       (clr_en),
  .abort_req    (abort_req),
  .async_status (async_status),
  .rsvd_cfg     (rsvd_cfg)
);

// File: tb/tb_tag_fault_reporter.sv
module tb_tag_fault_reporter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid;
  logic [63:0] evt_addr;
  logic        evt_write;
  logic        evt_unpriv;
  logic [1:0]  evt_regime_el;
  logic        evt_two_ranges;
  logic [63:0] ctrl_word;
  logic        clr_en;
  logic [1:0]  clr_el;
  logic        abort_req;
  logic [63:0] abort_addr;
  logic [7:0]  abort_syndrome;
  logic [7:0]  async_status;
  logic        rsvd_cfg;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tag_fault_reporter dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_addr(evt_addr),
    .evt_write(evt_write), .evt_unpriv(evt_unpriv), .evt_regime_el(evt_regime_el),
    .evt_two_ranges(evt_two_ranges), .ctrl_word(ctrl_word), .clr_en(clr_en),
    .clr_el(clr_el), .abort_req(abort_req), .abort_addr(abort_addr),
    .abort_syndrome(abort_syndrome), .async_status(async_status), .rsvd_cfg(rsvd_cfg)
  );

  typedef struct packed {
    logic       unpriv;
    logic [1:0] el;
    logic       two;
    logic       b55;
    logic       wr;
    logic [1:0] mu;
    logic [1:0] mp;
    logic       x_abort;
    logic       x_rsvd;
    logic [7:0] x_syn;
    logic [7:0] x_stat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 1'b1, 1'b0, 8'h51, 8'h00},
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 1'b1, 1'b0, 8'h91, 8'h00},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 8'h00, 8'h20},
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 2'd1, 1'b0, 1'b0, 8'h00, 8'h21},
    '{1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 8'h00, 8'h61},
    '{1'b0, 2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 2'd3, 1'b0, 1'b1, 8'h00, 8'h61},
    '{1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 2'd2, 2'd0, 1'b0, 1'b0, 8'h00, 8'h63},
    '{1'b0, 2'd2, 1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 8'h00, 8'h63},
    '{1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 2'd3, 2'd1, 1'b0, 1'b1, 8'h00, 8'h63},
    '{1'b0, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0, 8'h00, 8'h67}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_addr(input int idx, input logic b55);
    logic [63:0] a;
    a = 64'h0012_3456_789A_BC00 + 64'(idx * 16);
    a[55] = b55;
    return a;
  endfunction

  task automatic drive_evt(input logic up, input logic [1:0] el, input logic two,
                           input logic [63:0] a, input logic wr,
                           input logic [1:0] mu, input logic [1:0] mp);
    evt_valid      = 1'b1;
    evt_unpriv     = up;
    evt_regime_el  = el;
    evt_two_ranges = two;
    evt_addr       = a;
    evt_write      = wr;
    ctrl_word      = 64'h0;
    ctrl_word[39:38] = mu;
    ctrl_word[41:40] = mp;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] a1;
    logic [63:0] a2;
    rst_n = 1'b0;
    evt_valid = 1'b0; evt_addr = '0; evt_write = 1'b0; evt_unpriv = 1'b0;
    evt_regime_el = '0; evt_two_ranges = 1'b0; ctrl_word = '0;
    clr_en = 1'b0; clr_el = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(abort_req == 1'b0, "R1", 64'(abort_req), 64'h0);
    chk(async_status == 8'h00, "R1", 64'(async_status), 64'h0);
    chk(rsvd_cfg == 1'b0, "R1", 64'(rsvd_cfg), 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    chk(async_status == 8'h00 && !abort_req, "R1", 64'(async_status), 64'h0);

    // Vector table: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      drive_evt(TBL[i].unpriv, TBL[i].el, TBL[i].two, mk_addr(i, TBL[i].b55),
                TBL[i].wr, TBL[i].mu, TBL[i].mp);
      @(negedge clk);
      evt_valid = 1'b0;
      chk(abort_req == TBL[i].x_abort, "R2/R3 abort", 64'(abort_req), 64'(TBL[i].x_abort));
      chk(rsvd_cfg == TBL[i].x_rsvd, "R8 rsvd", 64'(rsvd_cfg), 64'(TBL[i].x_rsvd));
      chk(async_status == TBL[i].x_stat, "R5/R6/R7 status", 64'(async_status), 64'(TBL[i].x_stat));
      if (TBL[i].x_abort) begin
        chk(abort_syndrome == TBL[i].x_syn, "R4 syndrome", 64'(abort_syndrome), 64'(TBL[i].x_syn));
        chk(abort_addr == mk_addr(i, TBL[i].b55), "R4 addr", abort_addr, mk_addr(i, TBL[i].b55));
      end
      @(negedge clk);
      chk(abort_req == 1'b0 && rsvd_cfg == 1'b0, "R3/R8 pulse", 64'({abort_req, rsvd_cfg}), 64'h0);
    end

    // R10: idle with active mode fields
    ctrl_word = 64'h0;
    ctrl_word[39:38] = 2'd1;
    ctrl_word[41:40] = 2'd1;
    repeat (3) @(negedge clk);
    chk(!abort_req && !rsvd_cfg, "R10 idle", 64'({abort_req, rsvd_cfg}), 64'h0);
    chk(async_status == 8'h67, "R10 idle status", 64'(async_status), 64'h67);

    // R9: clear level 2, then level 0
    clr_en = 1'b1; clr_el = 2'd2;
    @(negedge clk);
    chk(async_status == 8'h47, "R9 clear el2", 64'(async_status), 64'h47);
    clr_el = 2'd0;
    @(negedge clk);
    clr_en = 1'b0;
    chk(async_status == 8'h44, "R9 clear el0", 64'(async_status), 64'h44);

    // R9: clear and set on level 1 in the same cycle
    drive_evt(1'b0, 2'd1, 1'b1, mk_addr(20, 1'b1), 1'b0, 2'd1, 2'd2);
    clr_en = 1'b1; clr_el = 2'd1;
    @(negedge clk);
    evt_valid = 1'b0; clr_en = 1'b0;
    chk(async_status == 8'h48, "R9 set wins", 64'(async_status), 64'h48);

    // R3 R4: back-to-back aborts
    a1 = mk_addr(30, 1'b0);
    a2 = mk_addr(31, 1'b1);
    drive_evt(1'b0, 2'd3, 1'b1, a1, 1'b1, 2'd2, 2'd1);
    @(negedge clk);
    chk(abort_req && abort_addr == a1, "R3 first", abort_addr, a1);
    drive_evt(1'b1, 2'd3, 1'b1, a2, 1'b0, 2'd1, 2'd2);
    @(negedge clk);
    evt_valid = 1'b0;
    chk(abort_req && abort_addr == a2, "R3 second", abort_addr, a2);
    chk(abort_syndrome == 8'h91, "R4 second syn", 64'(abort_syndrome), 64'h91);
    @(negedge clk);
    chk(!abort_req, "R3 end", 64'(abort_req), 64'h0);

    // R6: single range ignores bit 55
    drive_evt(1'b1, 2'd2, 1'b0, mk_addr(40, 1'b1), 1'b0, 2'd2, 2'd1);
    @(negedge clk);
    evt_valid = 1'b0;
    chk(async_status == 8'h49, "R6 single range", 64'(async_status), 64'h49);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule